// File: doc/BRIEF.md
# Pin Interrupt Request and EOI Engine

This engine keeps per-pin interrupt request state for a bank of interrupt input pins and decides when each pin should be sent to the processors. Line events arrive per pin with a level. The entry table that holds the mask, the trigger mode, the vector, the destination and the remote-IRR flag lives outside the block and is read through flat input buses. Requests leave one at a time on a valid/ready handshake that carries the pin, vector, destination and trigger mode. The block changes remote-IRR only through one-cycle set and clear strobes, which the owner of the table applies at the same clock edge.

Edge-triggered pins use a pending bitmap and a delivered bitmap, so that repeated high events are coalesced. A level-triggered pin is blocked while its remote-IRR is set. An end-of-interrupt (EOI) broadcast carries a vector and releases every level-triggered pin that uses that vector. A pin that is still pending is then redelivered. A per-pin counter of back-to-back EOI redeliveries detects an interrupt storm. When a storm is detected, the engine pushes the redelivery back by a programmable number of cycles instead of sending it at once.

Top module: `pin_irq_engine`

## Requirements
- R1: A line event with level 0 clears the pin's pending bit and withdraws any service of that pin that is not yet on the handshake. No request for that pin follows.
- R2: A line event with level 1 on an edge-triggered pin (level_trig_i bit = 0) clears its delivered bit. If the pending bit was already set, the event is coalesced and no new request is made.
- R3: A pin is serviced only when its mask bit is 0 and, if it is level-triggered (level_trig_i bit = 1), its remote_irr_i bit is 0. Otherwise it stays pending and no request is made.
- R4: A request carries the pin number, that pin's vector and destination, and req_level_o = the pin's trigger mode. When an edge-triggered request is accepted, the pin's delivered bit is set. When a level-triggered request is accepted, rirr_set_o pulses for one cycle on that pin.
- R5: In the cycle eoi_valid_i is high, rirr_clr_o pulses on every level-triggered pin whose vector equals eoi_vector_i. Edge-triggered pins and pins with other vectors are not touched.
- R6: After that clear, a pin that is unmasked and still pending is serviced again and its EOI counter increments. Otherwise its counter returns to 0.
- R7: When an EOI would bring a pin's counter to STORM_LIMIT, the counter returns to 0 and nothing is sent at once. A deferral timer starts for defer_len_i cycles (0 counts as 1).
- R8: When the deferral timer expires, every level-triggered pin that is pending, unmasked and has remote_irr_i = 0 is serviced.
- R9: A mask bit falling from 1 to 0 on a level-triggered pin that is pending with remote_irr_i = 0 causes that pin to be serviced.
- R10: pending_view_o equals the pending bitmap with the delivered bits cleared.
- R11: When several pins are ready together, the lowest pin number is presented first. A presented request keeps req_pin_o, req_vector_o and req_dest_o stable until req_ready_i is high.
- R12: Reset clears the pending, delivered and service bitmaps, all EOI counters and the deferral timer, and it sets the internal copy of the mask to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_evt_i | input | N | Per-pin line event strobe |
| line_lvl_i | input | N | Line level that goes with each event |
| mask_i | input | N | Entry mask bits |
| level_trig_i | input | N | Entry trigger mode, 1 = level |
| remote_irr_i | input | N | Entry remote-IRR bits |
| vector_i | input | N*VEC_W | Entry vectors, pin p at [p*VEC_W +: VEC_W] |
| dest_i | input | N*DEST_W | Entry destinations, pin p at [p*DEST_W +: DEST_W] |
| eoi_valid_i | input | 1 | EOI broadcast strobe |
| eoi_vector_i | input | VEC_W | Vector carried by the EOI |
| defer_len_i | input | DLY_W | Storm deferral length in cycles |
| req_valid_o | output | 1 | Delivery request valid |
| req_ready_i | input | 1 | Delivery request accepted |
| req_pin_o | output | PIN_W | Pin being delivered |
| req_vector_o | output | VEC_W | Vector of the request |
| req_dest_o | output | DEST_W | Destination of the request |
| req_level_o | output | 1 | Trigger mode of the request |
| rirr_set_o | output | N | Remote-IRR set strobes |
| rirr_clr_o | output | N | Remote-IRR clear strobes |
| pending_view_o | output | N | Pending bitmap with delivered bits removed |

## Verification
The bench builds the engine with four pins, 4-bit vectors and destinations, and STORM_LIMIT = 3. With these values it can sweep every pin through every combination of trigger mode and mask. It can also reach the storm threshold with only three EOIs per pin. Because the deferral length is set to six cycles, the bench can check that nothing is sent inside the deferral window and that the deferred requests arrive in the right order after it, for two pins that share one vector.

// File: rtl/pie_pkg.sv
package pie_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/pie_pin_state.sv
module pie_pin_state #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_evt_i,
  input  logic [N-1:0] line_lvl_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] level_trig_i,
  input  logic [N-1:0] remote_irr_i,
  input  logic [N-1:0] grant_oh_i,
  input  logic [N-1:0] acc_edge_oh_i,
  input  logic [N-1:0] redo_i,
  input  logic         expire_i,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] need_o,
  output logic [N-1:0] eligible_o,
  output logic [N-1:0] low_evt_o,
  output logic [N-1:0] view_o
);
  logic [N-1:0] pending_q, delivered_q, need_q, mask_q;
  logic [N-1:0] hi_evt, lo_evt, trig_line, unmask, wake, need_d;

  assign hi_evt     = line_evt_i & line_lvl_i;
  assign lo_evt     = line_evt_i & ~line_lvl_i;
  assign eligible_o = ~mask_i & (~level_trig_i | ~remote_irr_i);

  // level pins always retry; edge pins only on a fresh request
  assign trig_line = hi_evt & (level_trig_i | ~pending_q);
  assign unmask    = mask_q & ~mask_i & level_trig_i & pending_q & ~remote_irr_i;
  assign wake      = expire_i ? (level_trig_i & pending_q & ~remote_irr_i) : '0;
  assign need_d    = ((need_q & ~grant_oh_i & eligible_o) | trig_line | redo_i
                     | wake | unmask) & ~lo_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q   <= '0;
      delivered_q <= '0;
      need_q      <= '0;
      mask_q      <= '1;
    end else begin
      pending_q   <= (pending_q | hi_evt) & ~lo_evt;
      delivered_q <= (delivered_q | acc_edge_oh_i) & ~hi_evt;
      need_q      <= need_d;
      mask_q      <= mask_i;
    end
  end

  assign pending_o = pending_q;
  assign need_o    = need_q;
  assign low_evt_o = lo_evt;
  assign view_o    = pending_q & ~delivered_q;
endmodule

// File: rtl/pie_storm.sv
module pie_storm #(
  parameter int N           = 8,
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DLY_W       = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eoi_valid_i,
  input  logic [VEC_W-1:0]   eoi_vector_i,
  input  logic [N*VEC_W-1:0] vector_i,
  input  logic [N-1:0]       level_trig_i,
  input  logic [N-1:0]       mask_i,
  input  logic [N-1:0]       pending_i,
  input  logic [DLY_W-1:0]   defer_len_i,
  output logic [N-1:0]       rirr_clr_o,
  output logic [N-1:0]       redo_o,
  output logic               expire_o
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic [N-1:0]     hit, again, storm;
  logic [DLY_W-1:0] tmr_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;
    assign hit[i]   = eoi_valid_i && level_trig_i[i]
                      && (vector_i[i*VEC_W +: VEC_W] == eoi_vector_i);
    assign again[i] = hit[i] & ~mask_i[i] & pending_i[i];
    assign storm[i] = again[i] && (cnt_q == CNT_W'(STORM_LIMIT - 1));
    assign redo_o[i] = again[i] & ~storm[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (hit[i])   cnt_q <= redo_o[i] ? cnt_q + CNT_W'(1) : '0;
    end
  end

  // one shared timer; a storm on the expiry cycle re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else if ((|storm) && (tmr_q <= DLY_W'(1)))
      tmr_q <= (defer_len_i == '0) ? DLY_W'(1) : defer_len_i;
    else if (tmr_q != '0)
      tmr_q <= tmr_q - DLY_W'(1);
  end

  assign expire_o   = (tmr_q == DLY_W'(1));
  assign rirr_clr_o = hit;
endmodule

// File: rtl/pie_arbiter.sv
module pie_arbiter #(
  parameter int N      = 8,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int PIN_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        need_i,
  input  logic [N-1:0]        eligible_i,
  input  logic [N-1:0]        low_evt_i,
  input  logic [N-1:0]        level_trig_i,
  input  logic [N*VEC_W-1:0]  vector_i,
  input  logic [N*DEST_W-1:0] dest_i,
  input  logic                req_ready_i,
  output logic                req_valid_o,
  output logic [PIN_W-1:0]    req_pin_o,
  output logic [VEC_W-1:0]    req_vector_o,
  output logic [DEST_W-1:0]   req_dest_o,
  output logic                req_level_o,
  output logic [N-1:0]        grant_oh_o,
  output logic [N-1:0]        acc_oh_o
);
  logic [N-1:0]     inflight, cand;
  logic [PIN_W-1:0] pick;
  logic             load;

  assign inflight = req_valid_o ? (N'(1) << req_pin_o) : '0;
  assign cand     = need_i & eligible_i & ~low_evt_i & ~inflight;
  assign load     = ~req_valid_o | req_ready_i;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) if (cand[i]) pick = PIN_W'(i);
  end

  assign grant_oh_o = (load && (|cand)) ? (N'(1) << pick) : '0;
  assign acc_oh_o   = (req_valid_o && req_ready_i) ? (N'(1) << req_pin_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o  <= 1'b0;
      req_pin_o    <= '0;
      req_vector_o <= '0;
      req_dest_o   <= '0;
      req_level_o  <= 1'b0;
    end else if (load) begin
      req_valid_o <= |cand;
      if (|cand) begin
        req_pin_o    <= pick;
        req_vector_o <= vector_i[pick*VEC_W +: VEC_W];
        req_dest_o   <= dest_i[pick*DEST_W +: DEST_W];
        req_level_o  <= level_trig_i[pick];
      end
    end
  end
endmodule

// File: rtl/pin_irq_engine.sv
module pin_irq_engine
  import pie_pkg::*;
#(
  parameter int N           = 8,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DLY_W       = 20,
  localparam int PIN_W      = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        line_evt_i,
  input  logic [N-1:0]        line_lvl_i,
  input  logic [N-1:0]        mask_i,
  input  logic [N-1:0]        level_trig_i,
  input  logic [N-1:0]        remote_irr_i,
  input  logic [N*VEC_W-1:0]  vector_i,
  input  logic [N*DEST_W-1:0] dest_i,
  input  logic                eoi_valid_i,
  input  logic [VEC_W-1:0]    eoi_vector_i,
  input  logic [DLY_W-1:0]    defer_len_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [PIN_W-1:0]    req_pin_o,
  output logic [VEC_W-1:0]    req_vector_o,
  output logic [DEST_W-1:0]   req_dest_o,
  output logic                req_level_o,
  output logic [N-1:0]        rirr_set_o,
  output logic [N-1:0]        rirr_clr_o,
  output logic [N-1:0]        pending_view_o
);
  logic [N-1:0] pending, need, eligible, low_evt, grant_oh, acc_oh, redo;
  logic [N-1:0] acc_edge, acc_level;
  logic         expire;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      acc_level[i] = acc_oh[i] && (trig_e'(req_level_o) == TRIG_LEVEL);
      acc_edge[i]  = acc_oh[i] && (trig_e'(req_level_o) == TRIG_EDGE);
    end
  end

  pie_pin_state #(.N(N)) u_state (
    .clk_i, .rst_ni,
    .line_evt_i, .line_lvl_i, .mask_i, .level_trig_i, .remote_irr_i,
    .grant_oh_i(grant_oh), .acc_edge_oh_i(acc_edge), .redo_i(redo),
    .expire_i(expire), .pending_o(pending), .need_o(need),
    .eligible_o(eligible), .low_evt_o(low_evt), .view_o(pending_view_o)
  );

  pie_storm #(.N(N), .VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT), .DLY_W(DLY_W)) u_storm (
    .clk_i, .rst_ni, .eoi_valid_i, .eoi_vector_i, .vector_i, .level_trig_i,
    .mask_i, .pending_i(pending), .defer_len_i,
    .rirr_clr_o, .redo_o(redo), .expire_o(expire)
  );

  pie_arbiter #(.N(N), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_arb (
    .clk_i, .rst_ni, .need_i(need), .eligible_i(eligible), .low_evt_i(low_evt),
    .level_trig_i, .vector_i, .dest_i, .req_ready_i,
    .req_valid_o, .req_pin_o, .req_vector_o, .req_dest_o, .req_level_o,
    .grant_oh_o(grant_oh), .acc_oh_o(acc_oh)
  );

  assign rirr_set_o = acc_level;
endmodule

// File: rtl/pie_checker.sv
module pie_checker #(
  parameter int N      = 8,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int PIN_W = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      mask_i,
  input logic              eoi_valid_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [PIN_W-1:0]  req_pin_o,
  input logic [VEC_W-1:0]  req_vector_o,
  input logic [DEST_W-1:0] req_dest_o,
  input logic              req_level_o,
  input logic [N-1:0]      rirr_set_o,
  input logic [N-1:0]      rirr_clr_o
);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_pin_o)
      && $stable(req_vector_o) && $stable(req_dest_o)));

  p_set_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rirr_set_o) |-> (req_valid_o && req_ready_i && req_level_o));

  p_set_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rirr_set_o));

  p_clr_eoi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoi_valid_i |-> (rirr_clr_o == '0));

  p_load_unmasked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(!req_valid_o || req_ready_i))
      |-> ((($past(mask_i) >> req_pin_o) & N'(1)) == '0));
endmodule

bind pin_irq_engine pie_checker #(.N(N), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mask_i(mask_i), .eoi_valid_i(eoi_valid_i),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_pin_o(req_pin_o),
  .req_vector_o(req_vector_o), .req_dest_o(req_dest_o), .req_level_o(req_level_o),
  .rirr_set_o(rirr_set_o), .rirr_clr_o(rirr_clr_o)
);

// File: tb/sim_pin_irq_engine.sv
module sim_pin_irq_engine;
  localparam int N = 4, VW = 4, DW = 4, LIM = 3, DLW = 8, PW = 2, DLY = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    evt = '0, lvl = '0, mask_r = '1, trig_r = '0, rirr_tab;
  logic [N*VW-1:0] vec_f;
  logic [N*DW-1:0] dst_f;
  logic            eoi_v = 1'b0, ready = 1'b1;
  logic [VW-1:0]   eoi_vec = '0;
  logic            req_valid, req_level;
  logic [PW-1:0]   req_pin;
  logic [VW-1:0]   req_vec;
  logic [DW-1:0]   req_dst;
  logic [N-1:0]    rset, rclr, view;

  pin_irq_engine #(.N(N), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIM), .DLY_W(DLW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_evt_i(evt), .line_lvl_i(lvl), .mask_i(mask_r),
    .level_trig_i(trig_r), .remote_irr_i(rirr_tab), .vector_i(vec_f), .dest_i(dst_f),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec), .defer_len_i(DLW'(DLY)),
    .req_valid_o(req_valid), .req_ready_i(ready), .req_pin_o(req_pin),
    .req_vector_o(req_vec), .req_dest_o(req_dst), .req_level_o(req_level),
    .rirr_set_o(rset), .rirr_clr_o(rclr), .pending_view_o(view));

  // external entry table: remote-IRR follows the strobes
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rirr_tab <= '0;
    else        rirr_tab <= (rirr_tab & ~rclr) | rset;

  int nlog = 0, tests = 0, fails = 0;
  int log_pin [64];
  int log_vec [64];
  int log_dst [64];

  always @(negedge clk)
    if (rst_n && req_valid && ready) begin
      if (nlog < 64) begin
        log_pin[nlog] = int'(req_pin);
        log_vec[nlog] = int'(req_vec);
        log_dst[nlog] = int'(req_dst);
      end
      nlog = nlog + 1;
    end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic line(input int p, input logic l);
    evt[p] = 1'b1; lvl[p] = l;
    step(1);
    evt = '0;
  endtask

  task automatic eoi(input int v);
    eoi_v = 1'b1; eoi_vec = VW'(v);
    step(1);
    eoi_v = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    step(200000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n0;
    for (int p = 0; p < N; p++) begin
      vec_f[p*VW +: VW] = VW'(p + 5);
      dst_f[p*DW +: DW] = DW'(p + 9);
    end
    step(2);
    rst_n = 1'b1;
    step(2);
    // R12: reset state
    chk("R12 valid after reset", int'(req_valid), 0);
    chk("R12 view after reset", int'(view), 0);
    chk("R12 strobes after reset", int'(rset | rclr), 0);

    // sweep: every pin, both trigger modes, masked and unmasked
    for (int p = 0; p < N; p++)
      for (int t = 0; t < 2; t++)
        for (int m = 0; m < 2; m++) begin
          trig_r[p] = t[0]; mask_r[p] = m[0];
          step(1);
          n0 = nlog;
          line(p, 1'b1);
          step(6);
          chk("R3 service gated by mask", nlog - n0, m ? 0 : 1);
          if (!m) begin
            chk("R4 request pin", log_pin[n0], p);
            chk("R4 request vector", log_vec[n0], p + 5);
            chk("R4 request dest", log_dst[n0], p + 9);
          end
          if (t == 1) chk("R4 remote-IRR set", int'(rirr_tab[p]), m ? 0 : 1);
          else        chk("R10 view edge pin", int'(view[p]), m ? 1 : 0);
          line(p, 1'b0);
          step(1);
          chk("R1 view after low", int'(view[p]), 0);
          if (t == 1 && !m) begin
            eoi(p + 5);
            step(6);
            chk("R5 EOI clears remote-IRR", int'(rirr_tab[p]), 0);
            chk("R6 no redelivery when not pending", nlog - n0, 1);
          end
          mask_r[p] = 1'b1;
          trig_r[p] = 1'b0;
        end

    // R2: coalescing on an edge pin
    mask_r[1] = 1'b0; step(1);
    n0 = nlog;
    line(1, 1'b1); step(6);
    chk("R2 first edge delivered", nlog - n0, 1);
    chk("R10 view after delivery", int'(view[1]), 0);
    line(1, 1'b1); step(6);
    chk("R2 coalesced edge", nlog - n0, 1);
    chk("R2 delivered cleared", int'(view[1]), 1);
    line(1, 1'b0); line(1, 1'b1); step(6);
    chk("R2 new edge after low", nlog - n0, 2);
    line(1, 1'b0); mask_r[1] = 1'b1;

    // R1: low right after high withdraws the service
    mask_r[2] = 1'b0; step(1);
    n0 = nlog;
    line(2, 1'b1); line(2, 1'b0); step(6);
    chk("R1 low cancels service", nlog - n0, 0);
    mask_r[2] = 1'b1;

    // R3/R5/R6: level pin gated by remote-IRR
    trig_r[0] = 1'b1; mask_r[0] = 1'b0; step(1);
    n0 = nlog;
    line(0, 1'b1); step(6);
    chk("R3 level delivered", nlog - n0, 1);
    line(0, 1'b1); step(6);
    chk("R3 blocked by remote-IRR", nlog - n0, 1);
    eoi(15); step(6);
    chk("R5 other vector ignored", int'(rirr_tab[0]), 1);
    chk("R5 no delivery on other vector", nlog - n0, 1);
    eoi(5); step(6);
    chk("R6 redelivered after EOI", nlog - n0, 2);
    chk("R6 remote-IRR set again", int'(rirr_tab[0]), 1);
    line(0, 1'b0); eoi(5); step(4);
    chk("R5 cleared on final EOI", int'(rirr_tab[0]), 0);
    mask_r[0] = 1'b1; trig_r[0] = 1'b0;

    // R7/R8/R11: storm on two pins sharing one vector
    vec_f[1*VW +: VW] = VW'(10); vec_f[2*VW +: VW] = VW'(10);
    trig_r[2:1] = 2'b11; mask_r[2:1] = 2'b00; step(1);
    n0 = nlog;
    evt[2:1] = 2'b11; lvl[2:1] = 2'b11; step(1); evt = '0;
    step(8);
    chk("R11 both delivered", nlog - n0, 2);
    chk("R11 lowest first", log_pin[n0], 1);
    eoi(10); step(8);
    chk("R6 first EOI redelivers", nlog - n0, 4);
    eoi(10); step(8);
    chk("R6 second EOI redelivers", nlog - n0, 6);
    eoi(10); step(DLY - 2);
    chk("R7 storm deferred", nlog - n0, 6);
    step(8);
    chk("R8 expiry services both", nlog - n0, 8);
    chk("R8 expiry order", log_pin[n0 + 6], 1);
    chk("R8 expiry second pin", log_pin[n0 + 7], 2);
    evt[2:1] = 2'b11; lvl[2:1] = 2'b00; step(1); evt = '0;
    eoi(10); step(4);
    mask_r[2:1] = 2'b11; trig_r[2:1] = 2'b00;

    // R9: unmask of a pending level pin
    trig_r[3] = 1'b1; step(1);
    n0 = nlog;
    line(3, 1'b1); step(6);
    chk("R9 masked level held", nlog - n0, 0);
    chk("R10 masked pending view", int'(view[3]), 1);
    mask_r[3] = 1'b0; step(6);
    chk("R9 unmask services", nlog - n0, 1);
    line(3, 1'b0); eoi(8); step(4);
    mask_r[3] = 1'b1; trig_r[3] = 1'b0;

    // R11: hold while not ready
    ready = 1'b0; mask_r[0] = 1'b0; mask_r[3] = 1'b0; step(1);
    n0 = nlog;
    evt[0] = 1'b1; evt[3] = 1'b1; lvl[0] = 1'b1; lvl[3] = 1'b1; step(1); evt = '0;
    step(3);
    chk("R11 presented", int'(req_valid), 1);
    chk("R11 lowest presented", int'(req_pin), 0);
    step(3);
    chk("R11 held pin", int'(req_pin), 0);
    chk("R11 held vector", int'(req_vec), 5);
    ready = 1'b1; step(6);
    chk("R11 both accepted", nlog - n0, 2);
    chk("R11 second is pin 3", log_pin[n0 + 1], 3);
    line(0, 1'b0); line(3, 1'b0);
    mask_r[0] = 1'b1; mask_r[3] = 1'b1;

    // R12: counters cleared by reset
    trig_r[1] = 1'b1; mask_r[1] = 1'b0; step(1);
    line(1, 1'b1); step(6);
    eoi(10); step(6);
    eoi(10); step(6);
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(2);
    chk("R12 view cleared", int'(view), 0);
    n0 = nlog;
    line(1, 1'b1); step(6);
    eoi(10); step(6);
    chk("R12 counter cleared", nlog - n0, 2);

    report();
  end
endmodule